// File: doc/BRIEF.md
# Snooped Load Queue with Replay Marking

This block tracks the loads of one core that are allowed to run ahead of older loads, so that the core can still present sequentially consistent memory behaviour to other processors. The front end allocates a slot for each load in program order and receives the slot number as a tag. When the load later executes, possibly before older loads, it reports its tag and address, and the slot records the cache line it read.

Each write or upgrade seen on the coherence bus is checked against every executed slot in parallel. A matching line means another processor changed data that a speculative load has already consumed, so the slot is marked for replay. Loads retire from the head in program order. Retiring a marked load, or a load whose line is hit by a snoop in the same cycle, does not complete it: the queue empties itself, returns its tail to the head slot, and raises a one-cycle flush toward the pipeline so that the load and everything younger run again.

Top module: `snoop_load_queue`

## Requirements
- R1: After reset the queue is empty: `alloc_ready` is 1, `head_ready` is 0, `flush` is 0 and `alloc_tag` is 0.
- R2: An accepted allocation takes the slot shown on `alloc_tag`; tags advance by one per allocation and wrap from DEPTH-1 to 0. After DEPTH allocations without retirement `alloc_ready` is 0 and a further request leaves `alloc_tag` unchanged.
- R3: `head_ready` is 1 exactly when the oldest live slot has executed; execution of younger slots, in any order, does not raise it.
- R4: A commit request while `head_ready` is 1 and the head is unmarked retires the head without a flush, and the next slot becomes the head.
- R5: A snoop of kind write (2'b01) or upgrade (2'b10) whose line matches an executed slot marks it; committing that slot raises `flush`.
- R6: Lines are compared on address bits ADDR_W-1 down to LINE_OFF; the low LINE_OFF bits are ignored, and any difference above them is no match.
- R7: Snoops of kind read (2'b00) or idle (2'b11) never mark a slot.
- R8: A slot that has not yet executed is not compared, so a snoop before its execution does not mark it.
- R9: A flush appears as `flush` high for exactly the one cycle after the commit; then the queue is empty, younger slots are gone, and the next allocation gets the tag of the flushed head.
- R10: A matching write or upgrade snoop in the same cycle as the commit of the head still causes the flush.
- R11: A commit request while `head_ready` is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Request a slot for the next load in program order |
| alloc_ready | output | 1 | A free slot exists |
| alloc_tag | output | IDX_W | Slot the next allocation will take |
| exec_valid | input | 1 | A load has executed |
| exec_tag | input | IDX_W | Slot of the executed load |
| exec_addr | input | ADDR_W | Address read by the executed load |
| snoop_valid | input | 1 | A remote bus transaction is observed |
| snoop_kind | input | 2 | 00 read, 01 write, 10 upgrade, 11 idle |
| snoop_addr | input | ADDR_W | Address of the remote transaction |
| commit_req | input | 1 | Pipeline asks to retire the head load |
| head_ready | output | 1 | Head slot is live and executed |
| flush | output | 1 | One-cycle request to flush and refetch |

## Verification
The bench aims at the address compare boundary: same line with another offset must mark, the next line or a different upper byte must not, and a design that compared full addresses or too few bits would flush wrongly or miss a flush. It also drives a snoop before a slot executes and a snoop in the very cycle of commit; getting the first wrong causes needless flushes, getting the second wrong lets a stale load retire. After a flush it checks that the pulse lasts one cycle and that the freed tail restarts at the flushed head, since a stale tail would hand out tags out of program order.

// File: rtl/lq_pkg.sv
package lq_pkg;
   typedef enum logic [1:0] {
      SNP_READ    = 2'b00,
      SNP_WRITE   = 2'b01,
      SNP_UPGRADE = 2'b10,
      SNP_IDLE    = 2'b11
   } snoop_kind_e;

   // Only transactions that take ownership away from this core can
   // invalidate a speculative load result.
   function automatic logic takes_ownership(input logic [1:0] kind);
      return (kind == SNP_WRITE) || (kind == SNP_UPGRADE);
   endfunction
endpackage

// File: rtl/lq_ptr.sv
module lq_ptr #(
   parameter int DEPTH = 8,
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             load,
   input  logic [IDX_W-1:0] load_val,
   output logic [IDX_W-1:0] q
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

   always_ff @(posedge clk) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= load_val;
      else if (step) q <= (q == LAST) ? '0 : q + 1'b1;
   end

   // R2: wrapping keeps the pointer inside the slot range
   assert_ptr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      32'(q) < DEPTH);
endmodule

// File: rtl/lq_snoop_match.sv
module lq_snoop_match #(
   parameter int DEPTH  = 8,
   parameter int LINE_W = 26
) (
   input  logic              snoop_en,
   input  logic [LINE_W-1:0] snoop_line,
   input  logic [DEPTH-1:0]  armed,
   input  logic [LINE_W-1:0] line_tab [DEPTH],
   output logic [DEPTH-1:0]  hit
);
   for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign hit[g] = snoop_en & armed[g] & (line_tab[g] == snoop_line);
   end
endmodule

// File: rtl/snoop_load_queue.sv
module snoop_load_queue #(
   parameter int DEPTH    = 8,
   parameter int ADDR_W   = 32,
   parameter int LINE_OFF = 6,
   localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W   = $clog2(DEPTH + 1),
   localparam int LINE_W  = ADDR_W - LINE_OFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_valid,
   output logic              alloc_ready,
   output logic [IDX_W-1:0]  alloc_tag,
   input  logic              exec_valid,
   input  logic [IDX_W-1:0]  exec_tag,
   input  logic [ADDR_W-1:0] exec_addr,
   input  logic              snoop_valid,
   input  logic [1:0]        snoop_kind,
   input  logic [ADDR_W-1:0] snoop_addr,
   input  logic              commit_req,
   output logic              head_ready,
   output logic              flush
);
   import lq_pkg::*;

   if (DEPTH < 2) begin : g_bad_depth
      $error("snoop_load_queue: DEPTH must be at least 2");
   end
   if (LINE_OFF < 0 || LINE_OFF >= ADDR_W) begin : g_bad_line
      $error("snoop_load_queue: LINE_OFF must lie inside the address");
   end

   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

   logic [DEPTH-1:0]  vld_q, exe_q, rpl_q;
   logic [LINE_W-1:0] line_q [DEPTH];
   logic [CNT_W-1:0]  cnt_q;
   logic              flush_q;
   logic [IDX_W-1:0]  head_idx, tail_idx;
   logic [DEPTH-1:0]  hit;
   logic              snoop_en, commit_fire, do_flush, retire;
   logic              alloc_fire, exec_fire;

   assign snoop_en    = snoop_valid & takes_ownership(snoop_kind);
   assign alloc_ready = (cnt_q != FULL_CNT);
   assign alloc_tag   = tail_idx;
   assign head_ready  = vld_q[head_idx] & exe_q[head_idx];
   assign commit_fire = commit_req & head_ready;
   assign do_flush    = commit_fire & (rpl_q[head_idx] | hit[head_idx]);
   assign retire      = commit_fire & ~do_flush;
   assign alloc_fire  = alloc_valid & alloc_ready & ~do_flush;
   assign exec_fire   = exec_valid & (32'(exec_tag) < DEPTH) & ~do_flush
                        & vld_q[exec_tag];
   assign flush       = flush_q;

   lq_snoop_match #(.DEPTH(DEPTH), .LINE_W(LINE_W)) i_match (
      .snoop_en   (snoop_en),
      .snoop_line (snoop_addr[ADDR_W-1:LINE_OFF]),
      .armed      (vld_q & exe_q),
      .line_tab   (line_q),
      .hit        (hit)
   );

   lq_ptr #(.DEPTH(DEPTH)) i_head (
      .clk(clk), .rst_n(rst_n), .step(retire),
      .load(1'b0), .load_val(tail_idx), .q(head_idx)
   );

   lq_ptr #(.DEPTH(DEPTH)) i_tail (
      .clk(clk), .rst_n(rst_n), .step(alloc_fire),
      .load(do_flush), .load_val(head_idx), .q(tail_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
         exe_q <= '0;
         rpl_q <= '0;
      end else if (do_flush) begin
         vld_q <= '0;
         exe_q <= '0;
         rpl_q <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (alloc_fire && 32'(tail_idx) == i) begin
               vld_q[i] <= 1'b1;
               exe_q[i] <= 1'b0;
               rpl_q[i] <= 1'b0;
            end else if (retire && 32'(head_idx) == i) begin
               vld_q[i] <= 1'b0;
               exe_q[i] <= 1'b0;
               rpl_q[i] <= 1'b0;
            end else begin
               if (exec_fire && 32'(exec_tag) == i) exe_q[i] <= 1'b1;
               if (hit[i])                          rpl_q[i] <= 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (exec_fire && 32'(exec_tag) == i)
            line_q[i] <= exec_addr[ADDR_W-1:LINE_OFF];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         flush_q <= 1'b0;
      end else begin
         flush_q <= do_flush;
         if (do_flush) cnt_q <= '0;
         else          cnt_q <= cnt_q + CNT_W'(alloc_fire) - CNT_W'(retire);
      end
   end

   assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FULL_CNT);
   assert_empty_not_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0) |-> !head_ready);
   assert_marked_commit_flushes_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_req && head_ready && rpl_q[head_idx]) |=> flush);
   assert_flush_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !flush);
   assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> (alloc_ready && !head_ready));
   assert_idle_commit_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_req && !head_ready) |=> (!flush && $stable(head_idx)));
endmodule

// File: tb/test_snoop_load_queue.sv
module test_snoop_load_queue;
   localparam int DEPTH = 8;
   localparam int AW    = 32;
   localparam logic [31:0] BASE = 32'h1000_0040;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic alloc_valid = 1'b0, exec_valid = 1'b0, snoop_valid = 1'b0, commit_req = 1'b0;
   logic [2:0]  exec_tag = '0;
   logic [31:0] exec_addr = '0, snoop_addr = '0;
   logic [1:0]  snoop_kind = 2'b11;
   logic        alloc_ready, head_ready, flush;
   logic [2:0]  alloc_tag;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   snoop_load_queue #(.DEPTH(DEPTH), .ADDR_W(AW), .LINE_OFF(6)) i_snoop_load_queue (
      .clk(clk), .rst_n(rst_n),
      .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
      .exec_valid(exec_valid), .exec_tag(exec_tag), .exec_addr(exec_addr),
      .snoop_valid(snoop_valid), .snoop_kind(snoop_kind), .snoop_addr(snoop_addr),
      .commit_req(commit_req), .head_ready(head_ready), .flush(flush)
   );

   // kind, address, expected flush
   localparam int NVEC = 9;
   localparam logic [34:0] VEC [NVEC] = '{
      {2'b01, 32'h1000_0040, 1'b1},
      {2'b10, 32'h1000_0040, 1'b1},
      {2'b01, 32'h1000_007C, 1'b1},
      {2'b10, 32'h1000_0060, 1'b1},
      {2'b01, 32'h1000_0080, 1'b0},
      {2'b10, 32'h1000_0000, 1'b0},
      {2'b00, 32'h1000_0040, 1'b0},
      {2'b11, 32'h1000_0040, 1'b0},
      {2'b01, 32'h2000_0040, 1'b0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_alloc(output logic [2:0] tag);
      tag = alloc_tag;
      alloc_valid = 1'b1;
      @(negedge clk);
      alloc_valid = 1'b0;
   endtask

   task automatic do_exec(input logic [2:0] tag, input logic [31:0] addr);
      exec_valid = 1'b1; exec_tag = tag; exec_addr = addr;
      @(negedge clk);
      exec_valid = 1'b0;
   endtask

   task automatic do_snoop(input logic [1:0] kind, input logic [31:0] addr);
      snoop_valid = 1'b1; snoop_kind = kind; snoop_addr = addr;
      @(negedge clk);
      snoop_valid = 1'b0; snoop_kind = 2'b11;
   endtask

   task automatic do_commit();
      commit_req = 1'b1;
      @(negedge clk);
      commit_req = 1'b0;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      logic [2:0] t, t0, t1;
      logic [2:0] tags [DEPTH];
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 alloc_ready", 32'(alloc_ready), 1);
      chk("R1 head_ready", 32'(head_ready), 0);
      chk("R1 flush", 32'(flush), 0);
      chk("R1 alloc_tag", 32'(alloc_tag), 0);

      // R5 R6 R7 vector walk: one load, one snoop, then commit
      for (int v = 0; v < NVEC; v++) begin
         do_alloc(t);
         do_exec(t, BASE);
         do_snoop(VEC[v][34:33], VEC[v][32:1]);
         chk("R4 head_ready before commit", 32'(head_ready), 1);
         do_commit();
         chk($sformatf("R5 R6 R7 vector %0d flush", v), 32'(flush), 32'(VEC[v][0]));
         chk("R9 empty after commit", 32'(head_ready), 0);
         @(negedge clk);
      end

      // R8 snoop before execution is not compared
      do_alloc(t);
      do_snoop(2'b01, BASE);
      do_exec(t, BASE);
      do_commit();
      chk("R8 early snoop no flush", 32'(flush), 0);

      // R10 snoop in the same cycle as commit
      do_alloc(t);
      do_exec(t, BASE);
      snoop_valid = 1'b1; snoop_kind = 2'b10; snoop_addr = BASE + 32'h8;
      do_commit();
      snoop_valid = 1'b0; snoop_kind = 2'b11;
      chk("R10 same-cycle snoop flush", 32'(flush), 1);
      @(negedge clk);

      // R11 commit before the head executed is ignored
      do_alloc(t);
      do_commit();
      chk("R11 no flush", 32'(flush), 0);
      chk("R11 head still waiting", 32'(head_ready), 0);
      do_exec(t, BASE);
      chk("R3 head ready after exec", 32'(head_ready), 1);
      do_commit();
      chk("R11 later retire no flush", 32'(flush), 0);
      chk("R4 queue drained", 32'(head_ready), 0);

      // R2 fill, R3 out-of-order execution, R4 in-order retire
      for (int i = 0; i < DEPTH; i++) do_alloc(tags[i]);
      for (int i = 1; i < DEPTH; i++)
         chk("R2 tag sequence", 32'(tags[i]), 32'((tags[i-1] + 3'd1) % DEPTH));
      chk("R2 full", 32'(alloc_ready), 0);
      t = alloc_tag;
      do_alloc(t1);
      chk("R2 alloc while full ignored", 32'(alloc_tag), 32'(t));
      for (int i = DEPTH - 1; i >= 1; i--) do_exec(tags[i], BASE + 32'(i * 64));
      chk("R3 younger executed only", 32'(head_ready), 0);
      do_exec(tags[0], BASE);
      chk("R3 head executed", 32'(head_ready), 1);
      for (int i = 0; i < DEPTH; i++) begin
         do_commit();
         chk("R4 retire no flush", 32'(flush), 0);
      end
      chk("R4 room after drain", 32'(alloc_ready), 1);
      chk("R4 empty after drain", 32'(head_ready), 0);

      // R5 marked younger slot flushes only when it reaches the head
      do_alloc(t0);
      do_alloc(t1);
      do_exec(t0, BASE);
      do_exec(t1, BASE + 32'h100);
      do_snoop(2'b01, BASE + 32'h104);
      do_commit();
      chk("R5 unmarked head retires", 32'(flush), 0);
      do_commit();
      chk("R5 marked younger flushes", 32'(flush), 1);
      @(negedge clk);

      // R9 flush squashes younger slots and rewinds the tail
      do_alloc(t0);
      do_alloc(t1);
      do_exec(t0, BASE);
      do_exec(t1, BASE + 32'h200);
      do_snoop(2'b10, BASE);
      do_commit();
      chk("R9 flush pulse", 32'(flush), 1);
      chk("R9 tail rewound", 32'(alloc_tag), 32'(t0));
      @(negedge clk);
      chk("R9 pulse one cycle", 32'(flush), 0);
      chk("R9 younger squashed", 32'(head_ready), 0);
      chk("R9 room after flush", 32'(alloc_ready), 1);
      do_alloc(t);
      chk("R9 realloc at flushed head", 32'(t), 32'(t0));

      finish_run();
   end
endmodule